// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a word of four byte lanes, built to keep a shared data bus busy on every clock. A new command (read, write or idle) can be taken on each rising edge. Reads and writes can be mixed in any order without idle cycles. Every command and address is registered on entry. Read data leaves through an output register one edge after the command is captured. Write data is sampled two edges after its command, so the data phases of reads and writes never overlap on the bus.

The tristate bus is split into a data-in port, a registered data-out port and a registered drive flag that tells the pad when to drive. A high clock enable freezes every register, which stretches the current cycle. A synchronous reset empties the pipeline. It does not clear the memory contents. A read that closely follows a write to the same word returns the newly written bytes, because the pending write stage forwards them.

Top module: `zbt_sram`

## Requirements
- R1: While `rst` is high at an edge, the pipeline is emptied and `drive` is low after that edge. A command already in flight at a reset edge produces no output and no write.
- R2: A read command loads the addressed word into `dout` and sets `drive` high at the next enabled edge after it is captured.
- R3: The bus data of a write is sampled at the second enabled edge after the command edge, and the memory changes only then.
- R4: Byte select `byte_sel_n[i]` (active low) gates lane `din[8*i+7:8*i]`. Unselected lanes keep their contents. A write with all four selects high changes nothing. The selects are sampled on the same edge as the data.
- R5: A command is accepted only when `sel1_n` is low, `sel2` is high and `sel3_n` is low. If any one of them is inactive, the command neither reads nor writes, and `drive` is low in its data cycle.
- R6: With `load_n` high at an edge, no command is started.
- R7: Reads and writes may be issued on consecutive edges in any mix, and each produces its result with no wait states.
- R8: With `clk_en_n` high, an edge is ignored. `dout`, `drive`, the pipeline and the memory hold their values.
- R9: A read of a word with a write still pending in the pipeline returns the data of that write, with its selected bytes merged.
- R10: `drive` is low in the data cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low to start a command |
| wr_n | input | 1 | Low for write, high for read |
| addr | input | $clog2(WORDS) | Word address |
| byte_sel_n | input | LANES | Per-lane write selects, active low |
| din | input | 8*LANES | Bus data into the memory |
| dout | output | 8*LANES | Registered read data |
| drive | output | 1 | High when `dout` should drive the bus |

## Verification
The memory is first filled by back-to-back full writes and read back in one continuous burst. This separates correct write timing from data taken one edge early or late. A sweep that alternates writes and reads applies all sixteen byte-select masks, which tells lane steering apart from whole-word writes. Same-address reads are issued at gaps of one, two and three cycles after a write, which exposes a missing forwarding path or a stale output register. Further runs with each chip enable dropped, with load held high, with clock-enable stalls interleaved, and with a reset in mid-flight show that these cases leave the outputs and the stored words untouched.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int WORDS = 64,
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clk_en_n,
  input  logic                       sel1_n,
  input  logic                       sel2,
  input  logic                       sel3_n,
  input  logic                       load_n,
  input  logic                       wr_n,
  input  logic [$clog2(WORDS)-1:0]   addr,
  input  logic [LANES-1:0]           byte_sel_n,
  input  logic [8*LANES-1:0]         din,
  output logic [8*LANES-1:0]         dout,
  output logic                       drive
);
  localparam int AW = $clog2(WORDS);
  localparam int DW = 8 * LANES;

  logic [DW-1:0] mem [WORDS];
  logic          v1, w1, v2, w2;
  logic [AW-1:0] a1, a2;
  logic [DW-1:0] merged;

  wire go      = ~clk_en_n;
  wire chip_on = ~sel1_n & sel2 & ~sel3_n;
  wire start   = chip_on & ~load_n;
  wire wr_now  = v2 & w2;
  wire rd_now  = v1 & ~w1;

  always_comb begin
    merged = mem[a1];
    if (wr_now && a2 == a1)
      for (int i = 0; i < LANES; i++)
        if (!byte_sel_n[i]) merged[8*i +: 8] = din[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      v2    <= 1'b0;
      drive <= 1'b0;
      dout  <= '0;
    end else if (go) begin
      v1    <= start;
      w1    <= ~wr_n;
      a1    <= addr;
      v2    <= v1;
      w2    <= w1;
      a2    <= a1;
      drive <= rd_now;
      if (rd_now) dout <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && go && wr_now)
      for (int i = 0; i < LANES; i++)
        if (!byte_sel_n[i]) mem[a2][8*i +: 8] <= din[8*i +: 8];
  end
endmodule

module zbt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          load_n,
  input logic          v1,
  input logic          w1,
  input logic          drive,
  input logic [DW-1:0] dout
);
  a_r1_reset_empties: assert property (@(posedge clk)
    rst |=> (!drive && !v1));

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(dout) && $stable(drive)));

  a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !(!sel1_n && sel2 && !sel3_n)) |=> !v1);

  a_r6_no_load: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n) |=> !v1);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && v1 && !w1) |=> drive);

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && v1 && w1) |=> !drive);
endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .load_n(load_n), .v1(v1), .w1(w1), .drive(drive), .dout(dout)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int WORDS = 16;
  localparam int LANES = 4;
  localparam int AW = $clog2(WORDS);
  localparam int DW = 8 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic load_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LANES-1:0] byte_sel_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic drive;

  always #2.5 clk = ~clk;

  zbt_sram #(.WORDS(WORDS), .LANES(LANES)) u_zbt_sram (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .load_n(load_n), .wr_n(wr_n), .addr(addr),
    .byte_sel_n(byte_sel_n), .din(din), .dout(dout), .drive(drive)
  );

  int checks = 0, errors = 0, stepno = 0;
  bit done = 0;

  logic [DW-1:0] mm [WORDS];
  logic m1v = 0, m1w = 0, m2v = 0, m2w = 0, ed = 0;
  logic [AW-1:0] m1a = '0, m2a = '0;
  logic [DW-1:0] eo = '0;
  string m1tag = "R1", m2tag = "R1", etag = "R1";

  task automatic check_out();
    checks++;
    if (drive !== ed) begin
      errors++;
      $display("FAIL %s drive actual %0b expected %0b", etag, drive, ed);
    end
    if (ed) begin
      checks++;
      if (dout !== eo) begin
        errors++;
        $display("FAIL %s dout actual %h expected %h", etag, dout, eo);
      end
    end
  endtask

  // ce: 0 all active, 1 sel1_n off, 2 sel2 off, 3 sel3_n off
  task automatic step(input bit cen, input int ce, input bit ldn, input bit wrn,
                      input int a, input logic [LANES-1:0] bs, input string tag);
    logic [DW-1:0] d;
    bit ok;
    d = DW'(32'h9E37_79B9 * stepno + 32'h0123_4567);
    stepno++;
    clk_en_n = cen; sel1_n = (ce == 1); sel2 = (ce != 2); sel3_n = (ce == 3);
    load_n = ldn; wr_n = wrn; addr = AW'(a); byte_sel_n = bs; din = d;
    @(posedge clk);
    if (!cen) begin
      if (m2v && m2w)
        for (int i = 0; i < LANES; i++)
          if (!bs[i]) mm[m2a][8*i +: 8] = d[8*i +: 8];
      ed = m1v && !m1w;
      etag = (m1v && m1w) ? "R10" : m1tag;
      if (ed) eo = mm[m1a];
      m2v = m1v; m2w = m1w; m2a = m1a; m2tag = m1tag;
      ok = (ce == 0) && !ldn;
      m1v = ok; m1w = !wrn; m1a = AW'(a); m1tag = tag;
    end else if (!ed) etag = "R8";
    @(negedge clk);
    check_out();
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      m1v = 0; m2v = 0; ed = 0; etag = "R1";
      @(negedge clk);
      check_out();
    end
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input logic [LANES-1:0] bs, input string t);
    step(0, 0, 0, 0, a, bs, t);
  endtask
  task automatic rd(input int a, input logic [LANES-1:0] bs, input string t);
    step(0, 0, 0, 1, a, bs, t);
  endtask
  task automatic idle(input logic [LANES-1:0] bs, input string t);
    step(0, 0, 1, 1, 0, bs, t);
  endtask

  initial begin
    @(negedge clk);
    do_reset(3);

    for (int a = 0; a < WORDS; a++) wr(a, 4'h0, "R3");
    idle(4'h0, "R3"); idle(4'h0, "R3");

    for (int a = 0; a < WORDS; a++) rd(a, 4'hF, "R2");
    idle(4'hF, "R2"); idle(4'hF, "R2");

    for (int i = 0; i < WORDS; i++) begin
      wr(i, 4'(i), "R4");
      rd((i + 5) % WORDS, 4'(i + 7), "R7");
    end
    idle(4'h3, "R4"); idle(4'hA, "R4");
    for (int a = 0; a < WORDS; a++) rd(a, 4'hF, "R4");
    idle(4'hF, "R4");

    for (int g = 1; g <= 3; g++)
      for (int k = 0; k < 3; k++) begin
        wr(k + 2, 4'h0, "R9");
        for (int j = 1; j < g; j++) idle(4'(k * 5), "R9");
        rd(k + 2, 4'(k * 5), "R9");
        idle(4'(k + 9), "R9"); idle(4'hF, "R9");
      end
    rd(2, 4'hF, "R9"); rd(3, 4'hF, "R9"); rd(4, 4'hF, "R9");
    idle(4'hF, "R9"); idle(4'hF, "R9");

    for (int ce = 1; ce <= 3; ce++) begin
      step(0, ce, 0, 0, 7, 4'h0, "R5");
      step(0, ce, 0, 1, 7, 4'h0, "R5");
      step(0, ce, 0, 0, 8, 4'h0, "R5");
    end
    step(0, 0, 1, 0, 7, 4'h0, "R6");
    step(0, 0, 1, 0, 8, 4'h0, "R6");
    step(0, 0, 1, 1, 7, 4'h0, "R6");
    idle(4'h0, "R6");
    rd(7, 4'hF, "R5"); rd(8, 4'hF, "R6"); idle(4'hF, "R5"); idle(4'hF, "R5");

    for (int i = 0; i < 4 * WORDS; i++) begin
      if (i % 3 == 2) step(1, 0, 0, i % 2, (i * 7) % WORDS, 4'(i), "R8");
      else if (i % 2 == 0) wr((i * 3) % WORDS, 4'(i), "R8");
      else rd((i * 5) % WORDS, 4'(i), "R8");
    end
    idle(4'hF, "R8"); idle(4'hF, "R8");
    for (int a = 0; a < WORDS; a++) rd(a, 4'hF, "R8");
    idle(4'hF, "R8");

    rd(1, 4'hF, "R1");
    wr(6, 4'h0, "R1");
    do_reset(2);
    idle(4'h0, "R1"); idle(4'h0, "R1");
    rd(6, 4'hF, "R1"); idle(4'hF, "R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule